// File: doc/BRIEF.md
# Dual-Multiplier 40-bit Multiply-Accumulate Lane

This block is one arithmetic lane of a signal-processing datapath. It holds two signed 17x17 multipliers and produces a new 40-bit accumulator value from two 32-bit source words, an operation code and the current accumulator. It supports five operations:

- a single multiply-accumulate on the upper halves;
- a dot-product accumulate of both halves;
- a two-lane SIMD accumulate;
- a 16x32 extended-precision multiply-accumulate;
- a 32x32 extended-precision multiply-accumulate.

The two extended-precision operations combine the multipliers' partial products.

The lane also drives a store result taken from the new accumulator value. On the way out, that value is scaled by up to two bit positions, rounded half-up and saturated to 16 or 32 bits. A sticky flag records any clipping. Instruction decode and the register file sit outside the block. The surrounding pipeline feeds the accumulator in on `acc_in` and takes the updated value from `acc_out`.

Every operation except the 32x32 multiply is accepted in any cycle and completes in two cycles. The 32x32 multiply needs four partial products, so it runs the two multipliers twice. While it does so, it holds off the next operation for one cycle.

Top module: `dual_mac40`

## Requirements
- R1: Op code 0 (single MAC) returns `acc_in + 2*ah*bh` modulo 2^40. Here ah/bh are `src_a[31:16]`/`src_b[31:16]` and al/bl are `src_a[15:0]`/`src_b[15:0]`, all as signed 16-bit values.
- R2: Op code 1 (dot) returns `acc_in + 2*(ah*bh + al*bl)` modulo 2^40, in one operation.
- R3: Op code 2 (SIMD2) treats the accumulator as two 20-bit lanes with no carry between them. Bits [39:20] add bits [31:12] of the 32-bit value 2*ah*bh. Bits [19:0] add bits [31:12] of 2*al*bl. Each lane wraps modulo 2^20.
- R4: Op code 3 (16x32) returns `acc_in + floor(2*ah*B / 2^16)` modulo 2^40, where B is `src_b` as a signed 32-bit value.
- R5: Op code 4 (32x32) returns `acc_in + floor(A*B / 2^23)` modulo 2^40, where A and B are the signed 32-bit sources. Its result is due three cycles after acceptance. `in_ready` is low for exactly the one cycle after a 32x32 is accepted, and an operation offered in that cycle is ignored.
- R6: Every other operation is accepted whenever `in_ready` is high, one per cycle. Its result appears with `out_valid` high two cycles after acceptance. `out_valid` is low in every cycle that has no due result.
- R7: Op codes 5, 6 and 7 return `acc_in` unchanged.
- R8: `store_out` is the new accumulator value V scaled by 2^s. The scale s is `st_shift` read as signed 3-bit and clamped to the range -2..+2. For the 32-bit store (`st_w32`=1), the value is V*2^s rounded half-up to an integer. For the 16-bit store, it is V*2^s/2^16 rounded half-up.
- R9: The rounded store value saturates to [-2^31, 2^31-1] for the 32-bit store and to [-2^15, 2^15-1] for the 16-bit store. A 16-bit result is sign-extended into `store_out[31:16]`.
- R10: `ovf` goes high together with a result whose store value clipped while `st_en` was set with that operation. It stays high until reset.
- R11: After reset, `out_valid`, `acc_out`, `store_out` and `ovf` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | Low in the cycle that issues the second pass of a 32x32 multiply |
| op | input | 3 | Operation code |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| acc_in | input | 40 | Current accumulator value |
| st_en | input | 1 | Store requested; allows clipping to set `ovf` |
| st_w32 | input | 1 | 1: 32-bit store, 0: 16-bit store |
| st_shift | input | 3 | Signed scale exponent for the store path |
| out_valid | output | 1 | Result present on `acc_out` and `store_out` |
| acc_out | output | 40 | New accumulator value |
| store_out | output | 32 | Scaled, rounded, saturated store value |
| ovf | output | 1 | Sticky store-overflow flag |

## Verification
A result is due two cycles after its operation is accepted, or three cycles for the 32x32 multiply. The bench keeps a ring of expected results indexed by the cycle in which each one falls due. It drives and samples on the falling edge, and compares `out_valid`, `acc_out` and `store_out` against the entry for the current cycle. It also checks that `out_valid` stays low when no entry is due. The expected `in_ready` and the sticky flag are modelled cycle by cycle, including operations offered during the one-cycle stall, which must leave no trace in the outputs.

// File: rtl/dual_mac40.sv
module dual_mac40 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  op,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [39:0] acc_in,
  input  logic        st_en,
  input  logic        st_w32,
  input  logic [2:0]  st_shift,
  output logic        out_valid,
  output logic [39:0] acc_out,
  output logic [31:0] store_out,
  output logic        ovf
);
  localparam logic [2:0] OP_MAC   = 3'd0;
  localparam logic [2:0] OP_DOT   = 3'd1;
  localparam logic [2:0] OP_SIMD  = 3'd2;
  localparam logic [2:0] OP_MUL16 = 3'd3;
  localparam logic [2:0] OP_MUL32 = 3'd4;

  logic        s1_v, s1_pb, s1_en, s1_w32;
  logic [2:0]  s1_op, s1_sh;
  logic [31:0] s1_a, s1_b;
  logic [39:0] s1_acc;
  logic signed [33:0] p0, p1;
  logic signed [47:0] part_q;

  logic pass_b, accept, dual;
  logic [31:0] ua, ub;
  logic [2:0]  uop;
  logic signed [16:0] m0x, m0y, m1x, m1y;
  logic signed [33:0] m0, m1;

  assign pass_b   = s1_v && (s1_op == OP_MUL32) && !s1_pb;
  assign in_ready = !pass_b;
  assign accept   = in_valid && in_ready;

  assign ua   = pass_b ? s1_a  : src_a;
  assign ub   = pass_b ? s1_b  : src_b;
  assign uop  = pass_b ? s1_op : op;
  assign dual = (uop == OP_DOT) || (uop == OP_SIMD);

  assign m0x = pass_b ? {1'b0, ua[15:0]} : {ua[31], ua[31:16]};
  assign m0y = {ub[31], ub[31:16]};
  assign m1x = pass_b ? {1'b0, ua[15:0]} : (dual ? {ua[15], ua[15:0]} : {ua[31], ua[31:16]});
  assign m1y = dual ? {ub[15], ub[15:0]} : {1'b0, ub[15:0]};
  assign m0  = m0x * m0y;
  assign m1  = m1x * m1y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_pb <= 1'b0; s1_en <= 1'b0; s1_w32 <= 1'b0;
      s1_op <= '0; s1_sh <= '0; s1_a <= '0; s1_b <= '0; s1_acc <= '0;
      p0 <= '0; p1 <= '0;
    end else begin
      s1_v  <= accept || pass_b;
      s1_pb <= pass_b;
      p0    <= m0;
      p1    <= m1;
      if (accept) begin
        s1_op  <= op;     s1_a   <= src_a;  s1_b <= src_b;
        s1_acc <= acc_in; s1_en  <= st_en;
        s1_w32 <= st_w32; s1_sh  <= st_shift;
      end
    end
  end

  logic signed [47:0] pp;
  logic signed [63:0] full;
  logic signed [34:0] dsum;
  logic [39:0] nxt;

  assign pp   = ({{14{p0[33]}}, p0} <<< 16) + {{14{p1[33]}}, p1};
  assign full = ({{16{part_q[47]}}, part_q} <<< 16) + {{16{pp[47]}}, pp};
  assign dsum = {p0[33], p0} + {p1[33], p1};

  always_comb begin
    case (s1_op)
      OP_MAC:   nxt = s1_acc + {{5{p0[33]}}, p0, 1'b0};
      OP_DOT:   nxt = s1_acc + {{4{dsum[34]}}, dsum, 1'b0};
      OP_SIMD:  nxt = {s1_acc[39:20] + p0[30:11], s1_acc[19:0] + p1[30:11]};
      OP_MUL16: nxt = s1_acc + {{7{pp[47]}}, pp[47:15]};
      OP_MUL32: nxt = s1_acc + full[62:23];
      default:  nxt = s1_acc;
    endcase
  end

  logic [2:0] lsh;
  logic signed [47:0] sx, rr, rs;
  logic clip;
  logic [31:0] st_val;

  always_comb begin
    if ($signed(s1_sh) < -3'sd2)     lsh = 3'd0;
    else if ($signed(s1_sh) > 3'sd2) lsh = 3'd4;
    else                             lsh = s1_sh + 3'd2;
  end

  assign sx = $signed({{8{nxt[39]}}, nxt}) <<< lsh;
  assign rr = sx + (s1_w32 ? 48'sd2 : 48'sd131072);
  assign rs = s1_w32 ? (rr >>> 2) : (rr >>> 18);

  always_comb begin
    if (s1_w32) begin
      clip = !((&rs[47:31]) || !(|rs[47:31]));
      st_val = clip ? (rs[47] ? 32'h8000_0000 : 32'h7fff_ffff) : rs[31:0];
    end else begin
      clip = !((&rs[47:15]) || !(|rs[47:15]));
      st_val = clip ? (rs[47] ? 32'hffff_8000 : 32'h0000_7fff) : {{16{rs[15]}}, rs[15:0]};
    end
  end

  logic emit;
  assign emit = s1_v && !pass_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; acc_out <= '0; store_out <= '0; ovf <= 1'b0; part_q <= '0;
    end else begin
      out_valid <= emit;
      if (pass_b) part_q <= pp;
      if (emit) begin
        acc_out   <= nxt;
        store_out <= st_val;
        if (s1_en && clip) ovf <= 1'b1;
      end
    end
  end

  // R5
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_ready |=> in_ready);
  // R5
  stall_after_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_MUL32) |=> !in_ready);
  // R6
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op != OP_MUL32) |=> ##1 out_valid);
  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
  // R10
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf) |-> out_valid);
  // R9
  store16_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !s1_w32) |=> ((&store_out[31:15]) || !(|store_out[31:15])));
endmodule

// File: tb/tb_dual_mac40.sv
module tb_dual_mac40;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, in_ready, st_en, st_w32, out_valid, ovf;
  logic [2:0] op, st_shift;
  logic [31:0] src_a, src_b, store_out;
  logic [39:0] acc_in, acc_out;

  dual_mac40 dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .src_a(src_a), .src_b(src_b), .acc_in(acc_in), .st_en(st_en),
    .st_w32(st_w32), .st_shift(st_shift), .out_valid(out_valid), .acc_out(acc_out),
    .store_out(store_out), .ovf(ovf));

  int checks = 0, errors = 0, cyc = 0;
  bit prev_w32 = 0, mdl_ovf = 0;
  bit ev[8], eclip[8], een[8];
  logic [39:0] eacc[8];
  logic [31:0] est[8];
  logic [2:0]  eop[8];

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [39:0] ref_acc(input logic [2:0] o, input logic [31:0] a, b,
                                          input logic [39:0] acc);
    longint ah, al, bh, bl, as, bs, sa, t;
    logic [63:0] u, v;
    logic [19:0] hi, lo;
    ah = longint'($signed(a[31:16])); al = longint'($signed(a[15:0]));
    bh = longint'($signed(b[31:16])); bl = longint'($signed(b[15:0]));
    as = longint'($signed(a));        bs = longint'($signed(b));
    sa = longint'($signed(acc));
    case (o)
      3'd0: t = sa + 2 * ah * bh;
      3'd1: t = sa + 2 * (ah * bh + al * bl);
      3'd2: begin
        u = 64'(2 * ah * bh); v = 64'(2 * al * bl);
        hi = acc[39:20] + u[31:12]; lo = acc[19:0] + v[31:12];
        return {hi, lo};
      end
      3'd3: t = sa + ((2 * ah * bs) >>> 16);
      3'd4: t = sa + ((as * bs) >>> 23);
      default: t = sa;
    endcase
    return t[39:0];
  endfunction

  function automatic logic [32:0] ref_store(input logic [39:0] val, input logic [2:0] sh, input bit w32);
    int s;
    longint x, r;
    s = int'($signed(sh));
    if (s < -2) s = -2;
    if (s > 2) s = 2;
    x = longint'($signed(val)) * (longint'(1) << (s + 2));
    if (w32) begin
      r = (x + 2) >>> 2;
      if (r > 64'sd2147483647) return {1'b1, 32'h7fff_ffff};
      if (r < -64'sd2147483648) return {1'b1, 32'h8000_0000};
      return {1'b0, r[31:0]};
    end
    r = (x + 131072) >>> 18;
    if (r > 32767) return {1'b1, 32'h0000_7fff};
    if (r < -32768) return {1'b1, 32'hffff_8000};
    return {1'b0, r[31:0]};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] o, input logic [31:0] a, b,
                      input logic [39:0] acc, input bit en, w, input logic [2:0] sh);
    int sl, ts;
    bit rdy;
    logic [32:0] sr;
    @(negedge clk);
    sl = cyc % 8;
    check(out_valid == ev[sl], "R6", "out_valid", 64'(out_valid), 64'(ev[sl]));
    if (ev[sl]) begin
      check(acc_out == eacc[sl], tag(eop[sl]), "acc_out", 64'(acc_out), 64'(eacc[sl]));
      check(store_out == est[sl], eclip[sl] ? "R9" : "R8", "store_out", 64'(store_out), 64'(est[sl]));
      if (een[sl] && eclip[sl]) mdl_ovf = 1;
    end
    ev[sl] = 0;
    check(ovf == mdl_ovf, "R10", "ovf", 64'(ovf), 64'(mdl_ovf));
    rdy = !prev_w32;
    check(in_ready == rdy, "R5", "in_ready", 64'(in_ready), 64'(rdy));
    in_valid = v; op = o; src_a = a; src_b = b; acc_in = acc;
    st_en = en; st_w32 = w; st_shift = sh;
    if (v && rdy) begin
      ts = (cyc + ((o == 3'd4) ? 3 : 2)) % 8;
      ev[ts] = 1; eop[ts] = o; een[ts] = en;
      eacc[ts] = ref_acc(o, a, b, acc);
      sr = ref_store(eacc[ts], sh, w);
      eclip[ts] = sr[32]; est[ts] = sr[31:0];
      prev_w32 = (o == 3'd4);
    end else prev_w32 = 0;
    cyc++;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] r64;
    void'($urandom(32'd20240611));
    foreach (ev[i]) ev[i] = 0;
    rst_n = 0; in_valid = 0; op = 0; src_a = 0; src_b = 0; acc_in = 0;
    st_en = 0; st_w32 = 0; st_shift = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R11 reset state
    check(out_valid == 0, "R11", "out_valid", 64'(out_valid), 0);
    check(acc_out == 0, "R11", "acc_out", 64'(acc_out), 0);
    check(store_out == 0, "R11", "store_out", 64'(store_out), 0);
    check(ovf == 0, "R11", "ovf", 64'(ovf), 0);
    check(in_ready == 1, "R11", "in_ready", 64'(in_ready), 1);

    // R1, R2, R8 small values, no clipping
    step(1, 3'd0, 32'h0003_1111, 32'h0005_2222, 40'd100, 1, 1, 3'd0);
    step(1, 3'd1, 32'hfffe_0007, 32'h0003_fffd, 40'd7, 1, 1, 3'd0);
    // R8 half-up rounding, 16-bit store, positive and negative half
    step(1, 3'd7, 32'h0, 32'h0, 40'h00_0000_8000, 1, 0, 3'd0);
    step(1, 3'd6, 32'h0, 32'h0, 40'hff_ffff_8000, 1, 0, 3'd0);
    // R8 scale -2 and +2, and clamped codes
    step(1, 3'd5, 32'h0, 32'h0, 40'd3, 1, 1, 3'b110);
    step(1, 3'd5, 32'h0, 32'h0, 40'd3, 1, 1, 3'b010);
    step(1, 3'd5, 32'h0, 32'h0, 40'd3, 1, 1, 3'b100);
    step(1, 3'd5, 32'h0, 32'h0, 40'd3, 1, 1, 3'b011);
    // R7 reserved code leaves accumulator unchanged
    step(1, 3'd6, 32'hdead_beef, 32'h1234_5678, 40'h12_3456_789a, 0, 1, 3'd0);
    // R3 lane wrap with no carry between lanes
    step(1, 3'd2, 32'h4000_4000, 32'h4000_4000, {20'h7ffff, 20'hfffff}, 0, 1, 3'd0);
    // R4 16x32
    step(1, 3'd3, 32'h8000_0000, 32'h8000_0001, 40'd0, 0, 1, 3'd0);
    // R5 32x32 extremes, offer during stall must be ignored
    step(1, 3'd4, 32'h8000_0000, 32'h8000_0000, 40'd0, 0, 1, 3'd0);
    step(1, 3'd0, 32'h7fff_7fff, 32'h7fff_7fff, 40'd5, 1, 1, 3'd0);
    step(1, 3'd4, 32'h1234_5678, 32'hfedc_ba98, 40'h00_0000_1000, 0, 0, 3'd1);
    step(1, 3'd4, 32'h7fff_ffff, 32'h8000_0001, 40'd9, 0, 1, 3'd0);
    step(1, 3'd1, 32'h1111_2222, 32'h3333_4444, 40'd1, 0, 1, 3'd0);
    // R1 largest product, 32-bit store clips, R9/R10 flag rises
    step(1, 3'd0, 32'h8000_0000, 32'h8000_0000, 40'd0, 1, 1, 3'd0);
    // R9 16-bit negative saturation
    step(1, 3'd5, 32'h0, 32'h0, 40'h80_0000_0000, 1, 0, 3'd2);
    step(0, 3'd0, 32'h0, 32'h0, 40'd0, 0, 0, 3'd0);
    step(0, 3'd0, 32'h0, 32'h0, 40'd0, 0, 0, 3'd0);

    for (int n = 0; n < 1500; n++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if ($urandom % 8 == 0) a[31:16] = 16'h8000;
      if ($urandom % 8 == 0) b[15:0] = 16'h8000;
      r64 = {$urandom, $urandom};
      step(($urandom % 4) != 0, 3'($urandom), a, b, r64[39:0],
           1'($urandom), 1'($urandom), 3'($urandom));
    end
    repeat (5) step(0, 3'd0, 32'h0, 32'h0, 40'd0, 0, 0, 3'd0);
    summary();
    $finish;
  end
endmodule